// File: doc/BRIEF.md
# Address-Collision Busy Arbiter

This block sits between two independent access ports of a shared memory and decides who may write when both ports point at the same word at once. A collision exists only while both ports are enabled and their addresses are equal. When a collision appears, the port that had been presenting its address first keeps going. The other port sees an active-low busy, and its write strobe toward the memory is withheld. The decision is kept for as long as the collision lasts, and it is released in the same cycle the collision ends.

Wide words are built from several slices. One slice is built in arbitrating mode and drives busy. The other slices are built in follower mode: there, the busy pins are inputs that only block writes on their own side, so every slice of a word obeys a single decision. A combined clash output goes high whenever a busy is in force and can serve as an error interrupt. All sampling is synchronous to one clock. Busy and the gated write strobes respond combinationally to the current port inputs, and registers hold the port history and the winner.

Top module: `clash_arb`

## Requirements
- R1: In arbitrating mode (MASTER=1), both busy outputs are high (inactive) in any cycle where either enable is low or the two addresses differ.
- R2: When a collision begins and exactly one port presented the same enable and address in the previous cycle, that port wins and the other port's busy goes low in the same cycle.
- R3: When both ports arrive in the same cycle, the left port wins and only right busy goes low. This includes any collision present in the first cycle after reset, because reset clears the port history.
- R4: The two busy outputs are never low in the same cycle.
- R5: The write-enable inputs do not affect the decision: a read is granted or blocked exactly like a write.
- R6: Once decided, the winner is kept in every following cycle for as long as the collision continues, even when both addresses move together to a new equal value.
- R7: Busy returns high in the same cycle that the addresses stop matching or either enable drops.
- R8: A port's write strobe output is high only when that port is enabled, its write enable is high and its effective busy is inactive. In arbitrating mode the busy input pins are ignored.
- R9: In follower mode (MASTER=0), both busy outputs stay high, no arbitration takes place, and each busy input (active low) blocks writes only on its own port.
- R10: The clash output is high exactly when either port's effective busy is active: the driven busy in arbitrating mode, or the busy input in follower mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears history and winner |
| l_en | input | 1 | Left port enable, active high |
| l_addr | input | ADDR_W | Left port word address |
| l_we | input | 1 | Left port write request |
| r_en | input | 1 | Right port enable, active high |
| r_addr | input | ADDR_W | Right port word address |
| r_we | input | 1 | Right port write request |
| l_busy_in_n | input | 1 | Left busy from the arbitrating slice, active low; used in follower mode only |
| r_busy_in_n | input | 1 | Right busy from the arbitrating slice, active low; used in follower mode only |
| l_busy_n | output | 1 | Left busy, active low; held high in follower mode |
| r_busy_n | output | 1 | Right busy, active low; held high in follower mode |
| l_wr_go | output | 1 | Gated left write strobe toward the memory |
| r_wr_go | output | 1 | Gated right write strobe toward the memory |
| clash | output | 1 | High while either effective busy is active |

## Verification
The properties assume that port inputs change only between rising clock edges and stay steady across each edge. They also assume that the winner-hold rule is judged only after one full cycle out of reset, when the history registers are meaningful. The bench drives every input at the falling edge and samples the combinational outputs one nanosecond later, so each sampled value reflects the registered history from the previous rising edge. In follower mode the busy inputs are treated as arbitrary, and any mix of levels is legal, including both low together. The bench therefore applies each single-sided and both-high combination while a collision is present.

// File: rtl/clash_arb_pkg.sv
`timescale 1ns/1ps
package clash_arb_pkg;
   typedef enum logic [1:0] {
      WIN_NONE  = 2'd0,
      WIN_LEFT  = 2'd1,
      WIN_RIGHT = 2'd2
   } win_e;

   localparam int PORTS   = 2;
   localparam int P_LEFT  = 0;
   localparam int P_RIGHT = 1;
endpackage

// File: rtl/arrival_track.sv
`timescale 1ns/1ps
// Remembers what one port presented last cycle; held is high when the
// current enabled request equals the previous one (the port came earlier).
module arrival_track #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic              held
);
   logic              en_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         addr_q <= '0;
      end else begin
         en_q   <= en;
         addr_q <= addr;
      end
   end

   assign held = en & en_q & (addr_q == addr);
endmodule

// File: rtl/clash_core.sv
`timescale 1ns/1ps
// Picks the losing port on a collision and keeps the winner while it lasts.
module clash_core
   import clash_arb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             collide,
   input  logic [PORTS-1:0] held,
   output logic [PORTS-1:0] lose
);
   win_e win_q, win_d;

   always_comb begin
      lose  = '0;
      win_d = WIN_NONE;
      if (collide) begin
         unique case (win_q)
            WIN_LEFT:  win_d = WIN_LEFT;
            WIN_RIGHT: win_d = WIN_RIGHT;
            default: begin
               // right wins only if it alone was already there; ties go left
               if (held[P_RIGHT] && !held[P_LEFT]) win_d = WIN_RIGHT;
               else                                win_d = WIN_LEFT;
            end
         endcase
         lose[P_RIGHT] = (win_d == WIN_LEFT);
         lose[P_LEFT]  = (win_d == WIN_RIGHT);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= WIN_NONE;
      else        win_q <= win_d;
   end
endmodule

// File: rtl/write_gate.sv
`timescale 1ns/1ps
module write_gate (
   input  logic en,
   input  logic we,
   input  logic lose,
   output logic go
);
   assign go = en & we & ~lose;
endmodule

// File: rtl/clash_arb.sv
`timescale 1ns/1ps
module clash_arb
   import clash_arb_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int MASTER = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_en,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_we,
   input  logic              r_en,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_we,
   input  logic              l_busy_in_n,
   input  logic              r_busy_in_n,
   output logic              l_busy_n,
   output logic              r_busy_n,
   output logic              l_wr_go,
   output logic              r_wr_go,
   output logic              clash
);
   localparam bit IS_MASTER = (MASTER != 0);

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
         $error("clash_arb: ADDR_W must lie in 1..32");
      end
      if (MASTER != 0 && MASTER != 1) begin : g_bad_master
         $error("clash_arb: MASTER must be 0 or 1");
      end
   endgenerate

   logic [PORTS-1:0]  en_v, we_v, held_v, core_lose, eff_lose, go_v, bin_n_v;
   logic [ADDR_W-1:0] addr_v [PORTS];
   logic              collide;

   assign en_v            = {r_en, l_en};
   assign we_v            = {r_we, l_we};
   assign bin_n_v         = {r_busy_in_n, l_busy_in_n};
   assign addr_v[P_LEFT]  = l_addr;
   assign addr_v[P_RIGHT] = r_addr;

   assign collide = en_v[P_LEFT] & en_v[P_RIGHT] &
                    (addr_v[P_LEFT] == addr_v[P_RIGHT]);

   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_port
         arrival_track #(.ADDR_W(ADDR_W)) track_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_v[p]),
            .addr  (addr_v[p]),
            .held  (held_v[p])
         );
         write_gate gate_i (
            .en   (en_v[p]),
            .we   (we_v[p]),
            .lose (eff_lose[p]),
            .go   (go_v[p])
         );
      end
   endgenerate

   clash_core core_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .collide (collide),
      .held    (held_v),
      .lose    (core_lose)
   );

   // follower slices take the decision from the pins; arbiter ignores them
   assign eff_lose = IS_MASTER ? core_lose : ~bin_n_v;

   generate
      if (IS_MASTER) begin : g_drive_busy
         assign l_busy_n = ~core_lose[P_LEFT];
         assign r_busy_n = ~core_lose[P_RIGHT];
      end else begin : g_quiet_busy
         assign l_busy_n = 1'b1;
         assign r_busy_n = 1'b1;
      end
   endgenerate

   assign l_wr_go = go_v[P_LEFT];
   assign r_wr_go = go_v[P_RIGHT];
   assign clash   = |eff_lose;
endmodule

// File: rtl/clash_arb_chk.sv
`timescale 1ns/1ps
module clash_arb_chk #(
   parameter int ADDR_W = 11,
   parameter int MASTER = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              l_en,
   input logic [ADDR_W-1:0] l_addr,
   input logic              l_we,
   input logic              r_en,
   input logic [ADDR_W-1:0] r_addr,
   input logic              r_we,
   input logic              l_busy_in_n,
   input logic              r_busy_in_n,
   input logic              l_busy_n,
   input logic              r_busy_n,
   input logic              l_wr_go,
   input logic              r_wr_go,
   input logic              clash
);
   localparam bit ARB = (MASTER != 0);

   logic coll;
   logic armed;
   assign coll = l_en && r_en && (l_addr == r_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_one_loser_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!l_busy_n && !r_busy_n));

   assert_quiet_no_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ARB && !coll) |-> (l_busy_n && r_busy_n));

   assert_hold_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && coll && $past(coll) && !$past(r_busy_n)) |-> !r_busy_n);

   assert_hold_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && coll && $past(coll) && !$past(l_busy_n)) |-> !l_busy_n);

   assert_gate_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
      l_wr_go |-> (l_en && l_we && l_busy_n && (ARB || l_busy_in_n)));

   assert_gate_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
      r_wr_go |-> (r_en && r_we && r_busy_n && (ARB || r_busy_in_n)));

   assert_follower_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ARB |-> (l_busy_n && r_busy_n));

   assert_clash_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clash == (ARB ? (!l_busy_n || !r_busy_n) : (!l_busy_in_n || !r_busy_in_n)));
endmodule

bind clash_arb clash_arb_chk #(.ADDR_W(ADDR_W), .MASTER(MASTER)) chk_i (
   .clk(clk), .rst_n(rst_n),
   .l_en(l_en), .l_addr(l_addr), .l_we(l_we),
   .r_en(r_en), .r_addr(r_addr), .r_we(r_we),
   .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
   .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
   .l_wr_go(l_wr_go), .r_wr_go(r_wr_go), .clash(clash)
);

// File: tb/clash_arb_tb_top.sv
`timescale 1ns/1ps
module clash_arb_tb_top;
   localparam int AW     = 11;
   localparam int CLK_NS = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic le = 1'b0, lw = 1'b0, re = 1'b0, rw = 1'b0;
   logic [AW-1:0] la = '0, ra = '0;
   logic bil = 1'b1, bir = 1'b1;

   logic m_lb, m_rb, m_lg, m_rg, m_cl;
   logic s_lb, s_rb, s_lg, s_rg, s_cl;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_NS/2) clk = ~clk;

   clash_arb #(.ADDR_W(AW), .MASTER(1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .l_en(le), .l_addr(la), .l_we(lw),
      .r_en(re), .r_addr(ra), .r_we(rw),
      .l_busy_in_n(bil), .r_busy_in_n(bir),
      .l_busy_n(m_lb), .r_busy_n(m_rb),
      .l_wr_go(m_lg), .r_wr_go(m_rg), .clash(m_cl)
   );

   clash_arb #(.ADDR_W(AW), .MASTER(0)) dut_s (
      .clk(clk), .rst_n(rst_n),
      .l_en(le), .l_addr(la), .l_we(lw),
      .r_en(re), .r_addr(ra), .r_we(rw),
      .l_busy_in_n(bil), .r_busy_in_n(bir),
      .l_busy_n(s_lb), .r_busy_n(s_rb),
      .l_wr_go(s_lg), .r_wr_go(s_rg), .clash(s_cl)
   );

   // expected order: {l_busy_n, r_busy_n, l_wr_go, r_wr_go, clash}
   typedef struct packed {
      logic          le;
      logic [AW-1:0] la;
      logic          lw;
      logic          re;
      logic [AW-1:0] ra;
      logic          rw;
      logic [4:0]    ex;
      logic [3:0]    rq;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 11'h000, 1'b0, 1'b0, 11'h000, 1'b0, 5'b11000, 4'd1},  // R1 idle
      '{1'b1, 11'h005, 1'b1, 1'b1, 11'h006, 1'b1, 5'b11110, 4'd1},  // R1 differ
      '{1'b1, 11'h005, 1'b1, 1'b1, 11'h005, 1'b1, 5'b10101, 4'd2},  // R2 left earlier
      '{1'b1, 11'h005, 1'b1, 1'b1, 11'h005, 1'b1, 5'b10101, 4'd6},  // R6 hold
      '{1'b0, 11'h005, 1'b1, 1'b1, 11'h005, 1'b1, 5'b11010, 4'd7},  // R7 enable drop
      '{1'b1, 11'h005, 1'b0, 1'b1, 11'h005, 1'b1, 5'b01011, 4'd5},  // R5 read loses
      '{1'b1, 11'h005, 1'b1, 1'b1, 11'h005, 1'b1, 5'b01011, 4'd8},  // R8 write gated
      '{1'b1, 11'h005, 1'b1, 1'b1, 11'h007, 1'b1, 5'b11110, 4'd7},  // R7 addr moves
      '{1'b1, 11'h007, 1'b1, 1'b1, 11'h007, 1'b1, 5'b01011, 4'd2},  // R2 right earlier
      '{1'b1, 11'h7FF, 1'b1, 1'b1, 11'h7FF, 1'b1, 5'b01011, 4'd6},  // R6 both move
      '{1'b0, 11'h7FF, 1'b1, 1'b0, 11'h7FF, 1'b1, 5'b11000, 4'd7},  // R7 both off
      '{1'b1, 11'h003, 1'b1, 1'b1, 11'h003, 1'b1, 5'b10101, 4'd3},  // R3 tie
      '{1'b1, 11'h003, 1'b0, 1'b1, 11'h003, 1'b0, 5'b10001, 4'd5}   // R5 reads
   };

   task automatic check5(input string tag, input logic [4:0] act, input logic [4:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic check_master(input string tag, input logic [4:0] exp);
      check5(tag, {m_lb, m_rb, m_lg, m_rg, m_cl}, exp);
      // R4: never both busy low
      check5("R4", {4'b0000, (!m_lb && !m_rb)}, 5'b00000);
   endtask

   task automatic check_slave(input string tag, input logic [4:0] exp);
      check5(tag, {s_lb, s_rb, s_lg, s_rg, s_cl}, exp);
   endtask

   task automatic drive(input logic e0, input logic [AW-1:0] a0, input logic w0,
                        input logic e1, input logic [AW-1:0] a1, input logic w1);
      @(negedge clk);
      le = e0; la = a0; lw = w0;
      re = e1; ra = a1; rw = w1;
      #1;
   endtask

   task automatic summary;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
   endtask

   initial begin
      #(200000 * CLK_NS);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_master("R1 reset idle", 5'b11000);
      check_slave("R9 reset idle", 5'b11000);

      // table walk; follower slice sees busy inputs high: writes pass, no clash
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].le, VEC[i].la, VEC[i].lw, VEC[i].re, VEC[i].ra, VEC[i].rw);
         check_master($sformatf("R%0d vec%0d", VEC[i].rq, i), VEC[i].ex);
         check_slave($sformatf("R9 vec%0d", i),
                     {2'b11, VEC[i].le & VEC[i].lw, VEC[i].re & VEC[i].rw, 1'b0});
      end

      // R8: arbiter ignores busy pins; R9/R10: follower obeys them
      bil = 1'b0; bir = 1'b0;
      drive(1'b1, 11'h001, 1'b1, 1'b1, 11'h002, 1'b1);
      check_master("R8 pins ignored", 5'b11110);
      check_slave("R10 both pins low", 5'b11001);

      // both new on same address: R3 tie; follower blocks left only (R9)
      bil = 1'b0; bir = 1'b1;
      drive(1'b1, 11'h009, 1'b1, 1'b1, 11'h009, 1'b1);
      check_master("R3 tie left", 5'b10101);
      check_slave("R9 left pin only", 5'b11011);

      bil = 1'b1; bir = 1'b0;
      drive(1'b1, 11'h009, 1'b1, 1'b1, 11'h009, 1'b1);
      check_master("R6 hold left", 5'b10101);
      check_slave("R9 right pin only", 5'b11101);

      bil = 1'b1; bir = 1'b1;
      drive(1'b1, 11'h009, 1'b1, 1'b1, 11'h009, 1'b1);
      check_slave("R9 no arbitration", 5'b11110);

      // R2 then reset clears history: R3 tie after reset
      drive(1'b0, 11'h004, 1'b1, 1'b1, 11'h004, 1'b1);
      check_master("R7 left off", 5'b11010);
      drive(1'b1, 11'h004, 1'b1, 1'b1, 11'h004, 1'b1);
      check_master("R2 right earlier", 5'b01011);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_master("R3 tie after reset", 5'b10101);
      drive(1'b1, 11'h004, 1'b1, 1'b1, 11'h004, 1'b1);
      check_master("R6 hold after reset", 5'b10101);
      drive(1'b1, 11'h004, 1'b1, 1'b1, 11'h005, 1'b1);
      check_master("R7 addr split", 5'b11110);

      summary();
      $finish;
   end
endmodule